// File: doc/BRIEF.md
# Three-Level DMA Transfer Sequencer

This block owns a single active transfer descriptor and turns synchronization events into a stream of per-array move requests. A transfer has three nested levels: an array of `ACNT` bytes, a frame made of `BCNT` arrays, and a block made of `CCNT` frames. A mode bit in the descriptor chooses how much work one event releases. In array-sync mode an event releases one array. In frame-sync mode an event releases a whole frame. Each request gives a source address, a destination address and a byte length, and it is held until the downstream mover accepts it.

Descriptors live in a small parameter memory of 16 sets, each eight 32-bit words. A load strobe copies one set into the active descriptor. When the last event of a descriptor finishes, the block pulses a completion output that carries a 6-bit code. If the descriptor is not marked static, the block then replaces itself with the set named by its link field. A descriptor with every count zero is an error case: an event on it sets a missed-event flag and a pending bit, and later events are dropped until software clears that bit. A descriptor with only some counts zero finishes silently.

Top module: `dma3d_seq`

## Requirements
- R1: Set `s` occupies memory words `s*8+0..7`. Word 0 holds the code in [5:0], frame-sync in [8] and static in [9]. Word 1 is the source and word 3 the destination. Word 2 is {BCNT[31:16], ACNT[15:0]}. Word 4 is {dst B index, src B index} and word 6 is {dst C index, src C index}, each a signed 16-bit value. Word 5[15:0] is the link and word 7[15:0] is CCNT. `ld` with `ld_set` copies a set into the active descriptor; `req_len` equals ACNT.
- R2: After reset there is no request, no completion pulse, no error flag, no pending bit and the block is not busy.
- R3: In array-sync mode (word 0 bit 8 = 0) each event yields exactly one request, and BCNT×CCNT events finish the descriptor.
- R4: In frame-sync mode (word 0 bit 8 = 1) each event yields BCNT requests, and CCNT events finish the descriptor.
- R5: Within one frame, each next array's source and destination advance by their own sign-extended B index.
- R6: In array-sync mode, the first array of the next frame starts at the last array's address plus the C index, and BCNT is restored.
- R7: In frame-sync mode, the next frame starts at the frame's first array address plus the C index.
- R8: An event on a descriptor whose three counts are all zero issues no request. It sets `miss_err` and `sec_pend` in the next cycle, and later events issue nothing until `sec_clr` clears both.
- R9: An event on a descriptor with some, but not all, counts zero issues no request and raises no error. It pulses `done` in the next cycle with the code, clears `sec_pend`, and links when not static.
- R10: `done` is high for the single cycle after the last request of the final event is accepted, with `done_code` equal to word 0 bits [5:0].
- R11: On the final event of a non-static descriptor, the active descriptor is replaced by the set in link bits [3:0]; a self link repeats the same transfer.
- R12: A link value of 0xFFFF loads an all-zero (null) descriptor.
- R13: On the final event of a static descriptor (word 0 bit 9 = 1), the descriptor is kept with CCNT cleared, so later events complete as no-op descriptors.
- R14: While `req_valid` is high and `req_ready` is low, the request stays valid with unchanged source, destination and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_we | input | 1 | Parameter memory write enable |
| pm_addr | input | 7 | Parameter memory word address (set*8+word) |
| pm_wdata | input | 32 | Parameter memory write data |
| ld | input | 1 | Load the active descriptor from a set (idle only) |
| ld_set | input | 4 | Set index for `ld` |
| evt | input | 1 | Synchronization event strobe |
| sec_clr | input | 1 | Clears the pending bit and the error flag |
| req_ready | input | 1 | Downstream accepts the current request |
| req_valid | output | 1 | Array request valid |
| req_src | output | 32 | Array source address |
| req_dst | output | 32 | Array destination address |
| req_len | output | 16 | Array length in bytes |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 6 | Completion code of the finished descriptor |
| miss_err | output | 1 | Missed-event error flag |
| sec_pend | output | 1 | Pending bit that blocks events |
| busy | output | 1 | An event is being serviced |

## Verification
The assertions assume that `evt` and `ld` arrive only while `busy` is low, and that the parameter memory is not rewritten while a set is being linked. The stimulus keeps to these rules by design. Each event pulse is followed by waiting until every expected request has been accepted and the completion window has closed, and descriptors are written to memory before any load or event. Ready is drawn at random on every cycle to test the hold rule. Counts are kept small, and a few draws zero one or all counts, so the no-op and null paths show up among ordinary transfers.

// File: rtl/dma3d_seq.sv
module dma3d_seq #(
  parameter int SETS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pm_we,
  input  logic [$clog2(SETS)+2:0]     pm_addr,
  input  logic [31:0]                 pm_wdata,
  input  logic                        ld,
  input  logic [$clog2(SETS)-1:0]     ld_set,
  input  logic                        evt,
  input  logic                        sec_clr,
  input  logic                        req_ready,
  output logic                        req_valid,
  output logic [31:0]                 req_src,
  output logic [31:0]                 req_dst,
  output logic [15:0]                 req_len,
  output logic                        done,
  output logic [5:0]                  done_code,
  output logic                        miss_err,
  output logic                        sec_pend,
  output logic                        busy
);
  localparam int SW = $clog2(SETS);
  localparam int WORDS = SETS * 8;
  localparam logic [15:0] NULL_LINK = 16'hFFFF;

  logic [31:0] pm [WORDS];
  logic [31:0] rw [8];

  logic [5:0]  code;
  logic        fs, stat;
  logic [31:0] src, dst, fsrc, fdst;
  logic [15:0] acnt, bcnt, bcnt0, ccnt, link, arr_left;
  logic [15:0] sbi, dbi, sci, dci;
  logic        busy_q, err_q, sec_q, done_q;

  wire [31:0] sbx = {{16{sbi[15]}}, sbi};
  wire [31:0] dbx = {{16{dbi[15]}}, dbi};
  wire [31:0] scx = {{16{sci[15]}}, sci};
  wire [31:0] dcx = {{16{dci[15]}}, dci};

  wire use_ld   = ld && !busy_q;
  wire rd_null  = !use_ld && link == NULL_LINK;
  wire [SW-1:0] rd_set = use_ld ? ld_set : link[SW-1:0];

  wire null_set = acnt == 16'd0 && bcnt == 16'd0 && ccnt == 16'd0;
  wire dummy    = !null_set && (acnt == 16'd0 || bcnt == 16'd0 || ccnt == 16'd0);
  wire start    = !busy_q && evt && !sec_q && !use_ld;
  wire acc      = busy_q && req_ready;
  wire last_arr = arr_left == 16'd1;
  wire fin      = last_arr && ccnt == 16'd1 && (fs || bcnt == 16'd1);
  wire relink   = ((acc && fin) || (start && dummy)) && !stat;
  wire do_load  = use_ld || relink;

  wire unused_bits = ^{rw[0][31:10], rw[0][7:6], rw[5][31:16], rw[7][31:16]};

  always_ff @(posedge clk)
    if (pm_we) pm[pm_addr] <= pm_wdata;

  always_comb
    for (int k = 0; k < 8; k++)
      rw[k] = rd_null ? 32'd0 : pm[{rd_set, 3'(k)}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0; fs <= 1'b0; stat <= 1'b0;
      src <= '0; dst <= '0; fsrc <= '0; fdst <= '0;
      acnt <= '0; bcnt <= '0; bcnt0 <= '0; ccnt <= '0; link <= '0; arr_left <= '0;
      sbi <= '0; dbi <= '0; sci <= '0; dci <= '0;
      busy_q <= 1'b0; err_q <= 1'b0; sec_q <= 1'b0; done_q <= 1'b0; done_code <= '0;
    end else begin
      done_q <= 1'b0;
      if (sec_clr) begin
        sec_q <= 1'b0;
        err_q <= 1'b0;
      end
      if (start) begin
        if (null_set) begin
          err_q <= 1'b1;
          sec_q <= 1'b1;
        end else if (dummy) begin
          done_q    <= 1'b1;
          done_code <= code;
          sec_q     <= 1'b0;
        end else begin
          busy_q   <= 1'b1;
          arr_left <= fs ? bcnt : 16'd1;
          fsrc     <= src;
          fdst     <= dst;
        end
      end
      if (acc) begin
        arr_left <= arr_left - 16'd1;
        if (!last_arr) begin
          src <= src + sbx;
          dst <= dst + dbx;
        end else begin
          busy_q <= 1'b0;
          if (fin) begin
            done_q    <= 1'b1;
            done_code <= code;
            if (stat) ccnt <= 16'd0;
          end else if (fs) begin
            src  <= fsrc + scx;
            dst  <= fdst + dcx;
            ccnt <= ccnt - 16'd1;
          end else if (bcnt != 16'd1) begin
            src  <= src + sbx;
            dst  <= dst + dbx;
            bcnt <= bcnt - 16'd1;
          end else begin
            src  <= src + scx;
            dst  <= dst + dcx;
            bcnt <= bcnt0;
            ccnt <= ccnt - 16'd1;
          end
        end
      end
      if (do_load) begin
        code  <= rw[0][5:0];
        fs    <= rw[0][8];
        stat  <= rw[0][9];
        src   <= rw[1];
        acnt  <= rw[2][15:0];
        bcnt  <= rw[2][31:16];
        bcnt0 <= rw[2][31:16];
        dst   <= rw[3];
        sbi   <= rw[4][15:0];
        dbi   <= rw[4][31:16];
        link  <= rw[5][15:0];
        sci   <= rw[6][15:0];
        dci   <= rw[6][31:16];
        ccnt  <= rw[7][15:0];
      end
    end
  end

  assign req_valid = busy_q;
  assign busy      = busy_q;
  assign req_src   = src;
  assign req_dst   = dst;
  assign req_len   = acnt;
  assign done      = done_q;
  assign miss_err  = err_q;
  assign sec_pend  = sec_q;
endmodule

// File: rtl/dma3d_seq_chk.sv
module dma3d_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_src,
  input logic [31:0] req_dst,
  input logic [15:0] req_len,
  input logic        done,
  input logic        miss_err,
  input logic        sec_pend
);
  a_r14_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_src) && $stable(req_dst) && $stable(req_len));

  a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_len != 16'd0);

  a_r10_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(req_valid) |-> $past(req_ready));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  a_r8_ignore_pending: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pend && !req_valid |=> !req_valid);

  a_r9_err_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_err) |-> !done && sec_pend);
endmodule

bind dma3d_seq dma3d_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
  .done(done), .miss_err(miss_err), .sec_pend(sec_pend)
);

// File: tb/dma3d_seq_test.sv
module dma3d_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pm_we = 1'b0, ld = 1'b0, evt = 1'b0, sec_clr = 1'b0, req_ready = 1'b0;
  logic [6:0] pm_addr = '0;
  logic [31:0] pm_wdata = '0;
  logic [3:0] ld_set = '0;
  logic req_valid, done, miss_err, sec_pend, busy;
  logic [31:0] req_src, req_dst;
  logic [15:0] req_len;
  logic [5:0] done_code;

  always #5 clk = ~clk;

  dma3d_seq uut (
    .clk(clk), .rst_n(rst_n), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .ld(ld), .ld_set(ld_set), .evt(evt), .sec_clr(sec_clr), .req_ready(req_ready),
    .req_valid(req_valid), .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
    .done(done), .done_code(done_code), .miss_err(miss_err), .sec_pend(sec_pend), .busy(busy)
  );

  int errs = 0, checks = 0;
  logic [31:0] pmem [16][8];
  logic [5:0]  m_code;
  logic        m_fs, m_st, m_sec, m_err;
  logic [31:0] m_src, m_dst, m_fsrc, m_fdst;
  logic [15:0] m_a, m_b, m_b0, m_c, m_link, m_sbi, m_dbi, m_sci, m_dci;
  logic [31:0] e_src [64];
  logic [31:0] e_dst [64];
  int          e_n;
  bit          e_done;
  logic [5:0]  e_code;

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_set(input int s, input logic [5:0] code, input logic fs, input logic st,
                         input logic [31:0] src, input logic [31:0] dst,
                         input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                         input logic [15:0] sbi, input logic [15:0] dbi,
                         input logic [15:0] sci, input logic [15:0] dci, input logic [15:0] link);
    logic [31:0] w [8];
    w[0] = {22'd0, st, fs, 2'd0, code};
    w[1] = src; w[2] = {b, a}; w[3] = dst; w[4] = {dbi, sbi};
    w[5] = {16'd0, link}; w[6] = {dci, sci}; w[7] = {16'd0, c};
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      pm_we = 1'b1; pm_addr = {s[3:0], k[2:0]}; pm_wdata = w[k];
      pmem[s][k] = w[k];
    end
    @(negedge clk) pm_we = 1'b0;
  endtask

  task automatic m_load(input int s, input bit nul);
    logic [31:0] w [8];
    for (int k = 0; k < 8; k++) w[k] = nul ? 32'd0 : pmem[s][k];
    m_code = w[0][5:0]; m_fs = w[0][8]; m_st = w[0][9];
    m_src = w[1]; m_a = w[2][15:0]; m_b = w[2][31:16]; m_b0 = w[2][31:16];
    m_dst = w[3]; m_sbi = w[4][15:0]; m_dbi = w[4][31:16];
    m_link = w[5][15:0]; m_sci = w[6][15:0]; m_dci = w[6][31:16]; m_c = w[7][15:0];
  endtask

  task automatic load(input int s);
    @(negedge clk) begin ld = 1'b1; ld_set = s[3:0]; end
    @(negedge clk) ld = 1'b0;
    m_load(s, 1'b0);
  endtask

  task automatic clear_pending();
    @(negedge clk) sec_clr = 1'b1;
    @(negedge clk) sec_clr = 1'b0;
    m_sec = 1'b0; m_err = 1'b0;
  endtask

  task automatic m_relink();
    m_load(int'(m_link[3:0]), m_link == 16'hFFFF);
  endtask

  task automatic m_final();
    e_done = 1'b1; e_code = m_code;
    if (m_st) m_c = 16'd0;
    else m_relink();
  endtask

  task automatic model_event();
    e_n = 0; e_done = 1'b0;
    if (m_sec) return;
    if (m_a == 0 && m_b == 0 && m_c == 0) begin
      m_err = 1'b1; m_sec = 1'b1; return;
    end
    if (m_a == 0 || m_b == 0 || m_c == 0) begin
      e_done = 1'b1; e_code = m_code; m_sec = 1'b0;
      if (!m_st) m_relink();
      return;
    end
    if (m_fs) begin
      m_fsrc = m_src; m_fdst = m_dst;
      for (int i = 0; i < int'(m_b); i++) begin
        e_src[e_n] = m_src; e_dst[e_n] = m_dst; e_n++;
        if (i < int'(m_b) - 1) begin m_src = m_src + sx(m_sbi); m_dst = m_dst + sx(m_dbi); end
      end
      if (m_c > 1) begin
        m_src = m_fsrc + sx(m_sci); m_dst = m_fdst + sx(m_dci); m_c = m_c - 1;
      end else m_final();
    end else begin
      e_src[0] = m_src; e_dst[0] = m_dst; e_n = 1;
      if (m_b > 1) begin
        m_src = m_src + sx(m_sbi); m_dst = m_dst + sx(m_dbi); m_b = m_b - 1;
      end else if (m_c > 1) begin
        m_src = m_src + sx(m_sci); m_dst = m_dst + sx(m_dci); m_b = m_b0; m_c = m_c - 1;
      end else m_final();
    end
  endtask

  task automatic do_event(input string tag);
    int got, dn, post;
    bit hold;
    logic [31:0] hs, hd;
    logic [15:0] hl;
    logic [15:0] exp_len;
    exp_len = m_a;
    model_event();
    @(negedge clk) evt = 1'b1;
    @(negedge clk) evt = 1'b0;
    got = 0; dn = 0; post = 0; hold = 1'b0;
    for (int cyc = 0; cyc < 400 && !(got == e_n && post >= 2); cyc++) begin
      if (done) begin
        dn++;
        check("R10 completion code", 32'(done_code), 32'(e_code));
      end
      if (hold) begin
        check("R14 held valid", 32'(req_valid), 32'd1);
        check("R14 held source", req_src, hs);
        check("R14 held destination", req_dst, hd);
        check("R14 held length", 32'(req_len), 32'(hl));
      end
      hold = 1'b0;
      if (got < e_n) begin
        req_ready = ($urandom_range(0, 2) != 0);
        #1;
        if (req_valid && req_ready) begin
          check({"R1 length ", tag}, 32'(req_len), 32'(exp_len));
          check({"source ", tag}, req_src, e_src[got]);
          check({"destination ", tag}, req_dst, e_dst[got]);
          got++;
        end else if (req_valid) begin
          hold = 1'b1; hs = req_src; hd = req_dst; hl = req_len;
        end
      end else begin
        req_ready = 1'b0;
        post++;
        check("R3 no extra request", 32'(req_valid), 32'd0);
      end
      @(negedge clk);
    end
    req_ready = 1'b0;
    check({"R4 request count ", tag}, 32'(got), 32'(e_n));
    check({"R10 completion pulses ", tag}, 32'(dn), 32'(e_done));
    check("R8 error flag", 32'(miss_err), 32'(m_err));
    check("R8 pending bit", 32'(sec_pend), 32'(m_sec));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL R3 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    m_sec = 1'b0; m_err = 1'b0;
    m_load(0, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset valid", 32'(req_valid), 32'd0);
    check("R2 reset done", 32'(done), 32'd0);
    check("R2 reset error", 32'(miss_err), 32'd0);
    check("R2 reset pending", 32'(sec_pend), 32'd0);
    check("R2 reset busy", 32'(busy), 32'd0);

    put_set(0, 6'd5, 1'b0, 1'b0, 32'h1000, 32'h8000, 16'd4, 16'd3, 16'd2,
            16'd16, 16'hFFF8, 16'h0100, 16'h0040, 16'd0);
    load(0);
    for (int e = 0; e < 8; e++) do_event("R3 R5 R6 R11");

    put_set(1, 6'h2A, 1'b1, 1'b0, 32'h2000, 32'h9000, 16'd8, 16'd4, 16'd3,
            16'd8, 16'h0020, 16'hFFC0, 16'h0200, 16'd2);
    put_set(2, 6'h11, 1'b0, 1'b0, 32'h3000, 32'hA000, 16'd0, 16'd2, 16'd1,
            16'd4, 16'd4, 16'd0, 16'd0, 16'd3);
    put_set(3, 6'd7, 1'b0, 1'b0, 32'h4000, 32'hB000, 16'd2, 16'd1, 16'd1,
            16'd0, 16'd0, 16'd0, 16'd0, 16'hFFFF);
    load(1);
    for (int e = 0; e < 3; e++) do_event("R4 R5 R7");
    do_event("R9 no-op set");
    do_event("R11 link");
    do_event("R12 null set");
    do_event("R8 ignored");
    clear_pending();
    do_event("R8 null again");

    put_set(4, 6'd9, 1'b0, 1'b1, 32'h5000, 32'hC000, 16'd3, 16'd2, 16'd1,
            16'd3, 16'd3, 16'd0, 16'd0, 16'd0);
    clear_pending();
    load(4);
    for (int e = 0; e < 3; e++) do_event("R13 static");

    for (int s = 5; s < 16; s++) begin
      logic [15:0] a, b, c, lk;
      a = 16'($urandom_range(1, 16));
      b = 16'($urandom_range(1, 4));
      c = 16'($urandom_range(1, 3));
      case ($urandom_range(0, 7))
        0: a = 16'd0;
        1: begin a = 16'd0; b = 16'd0; c = 16'd0; end
        default: ;
      endcase
      lk = ($urandom_range(0, 7) == 0) ? 16'hFFFF : 16'($urandom_range(5, 15));
      put_set(s, 6'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
              $urandom, $urandom, a, b, c,
              16'($urandom_range(0, 64)) - 16'd32, 16'($urandom_range(0, 64)) - 16'd32,
              16'($urandom_range(0, 512)) - 16'd256, 16'($urandom_range(0, 512)) - 16'd256, lk);
    end
    for (int it = 0; it < 40; it++) begin
      clear_pending();
      load($urandom_range(5, 15));
      for (int e = 0; e < 14; e++) begin
        do_event("random R5 R6 R7");
        if (e_done || m_err) break;
      end
      do_event("random R11 follow-on");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule